// File: doc/BRIEF.md
# Programmable One-Shot/Periodic Down Timer

A single countdown timer channel behind a small synchronous register port. Software programs one configuration word that carries an enable flag, a repeat flag and a 29-bit start value. Once the word is written with the enable flag set, the counter decrements on every clock. When it has passed zero it raises a level interrupt. In repeat mode it reloads the start value and keeps going. In one-shot mode it goes idle.

The interrupt stays high until software writes a one to the clear bit of a second register. That register also reads back the pending state. A start value of N gives an expiry N+1 clocks after the write. A software tick period is therefore programmed as (clock rate / tick rate) minus one.

Writes take effect on the clock edge where `wrEn` is high. Reads are combinational from `addr`.

Top module: `cnt_down_timer`

## Requirements
- R1: Reset leaves every register at zero with `irq` low. Reading offset 0x0 returns the enable flag at bit 31, the repeat flag at bit 30 and the 29-bit start value at bits 28:0. Bit 29 always reads zero.
- R2: Writing offset 0x0 with bit 31 set and start value N raises `irq` at the (N+1)th clock edge after the write edge, and not earlier.
- R3: A start value of 0 raises `irq` at the first clock edge after the write edge.
- R4: With bit 30 set, the timer reloads N on expiry and raises `irq` again every N+1 clocks.
- R5: With bit 30 clear, the timer stops after one expiry, and no further interrupt occurs until the next write to offset 0x0.
- R6: `irq` stays high until a write to offset 0x4 with bit 30 set. A write to offset 0x4 with bit 30 clear leaves it unchanged.
- R7: Reading offset 0x4 returns the pending interrupt at bit 30, with all other bits zero.
- R8: Writing offset 0x0 with bit 31 clear stops counting. This includes writing zero. No expiry follows, whatever start value is written.
- R9: Writing offset 0x0 while the timer runs restarts the countdown from the new value on the next clock.
- R10: If an expiry and a clear write fall on the same edge, `irq` stays high.
- R11: A write to offset 0x0 on the edge where the count would expire suppresses that expiry and restarts the countdown.
- R12: The largest start value, 0x1FFFFFFF, is stored and read back intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; also the count tick |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Byte offset of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `addr` |
| irq | output | 1 | Level interrupt, held until cleared |

## Verification
The countdown is tried with a mid-range one-shot value, the zero start value and a short repeating period. The first separates the N+1 count from an N count. The second exposes an off-by-one at the low end. The third shows whether reloading keeps the exact period across several expiries. Further patterns target priorities: a reload mid-count, a reload on the exact expiry edge, and a clear on the exact expiry edge. A disable with a non-zero value is also tried. Together these show which of two same-edge events wins.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  parameter int unsigned CNT_W = 29;

  // Strobes sent from register control to the counting datapath
  typedef struct packed {
    logic             load;     // start or restart the countdown
    logic             halt;     // stop counting
    logic             irqClr;   // request to drop the pending interrupt
    logic [CNT_W-1:0] startVal; // value loaded on a start
  } tmrStrobe_t;
endpackage

// File: rtl/dtmr_regs.sv
module dtmr_regs
  import dtmr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned EN_BIT   = 31,
  parameter int unsigned PER_BIT  = 30,
  parameter int unsigned CLR_BIT  = 30,
  parameter int unsigned LOAD_OFF = 0,
  parameter int unsigned CTRL_OFF = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              irqPending,
  output tmrStrobe_t        strb,
  output logic              cfgPeriodic,
  output logic [CNT_W-1:0]  cfgCount,
  output logic [DATA_W-1:0] rdData
);
  localparam logic [ADDR_W-1:0] LOAD_A = ADDR_W'(LOAD_OFF);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFF);

  logic loadHit;
  logic ctrlHit;
  logic cfgEnable;

  assign loadHit = wrEn && (addr == LOAD_A);
  assign ctrlHit = wrEn && (addr == CTRL_A);

  always_comb begin
    strb          = '0;
    strb.load     = loadHit && wrData[EN_BIT];
    strb.halt     = loadHit && !wrData[EN_BIT];
    strb.irqClr   = ctrlHit && wrData[CLR_BIT];
    strb.startVal = wrData[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgEnable   <= 1'b0;
      cfgPeriodic <= 1'b0;
      cfgCount    <= '0;
    end else if (loadHit) begin
      cfgEnable   <= wrData[EN_BIT];
      cfgPeriodic <= wrData[PER_BIT];
      cfgCount    <= wrData[CNT_W-1:0];
    end
  end

  always_comb begin
    rdData = '0;
    if (addr == LOAD_A) begin
      rdData[EN_BIT]      = cfgEnable;
      rdData[PER_BIT]     = cfgPeriodic;
      rdData[CNT_W-1:0]   = cfgCount;
    end else if (addr == CTRL_A) begin
      rdData[CLR_BIT]     = irqPending;
    end
  end
endmodule

// File: rtl/dtmr_core.sv
module dtmr_core
  import dtmr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strb,
  input  logic             cfgPeriodic,
  input  logic [CNT_W-1:0] cfgCount,
  output logic             irqPending,
  output logic             expireEv,
  output logic             runActive
);
  logic [CNT_W-1:0] countQ;
  logic             atZero;

  assign atZero   = (countQ == '0);
  // A register write on the same edge takes priority over an expiry
  assign expireEv = runActive && atZero && !strb.load && !strb.halt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ    <= '0;
      runActive <= 1'b0;
    end else if (strb.load) begin
      countQ    <= strb.startVal;
      runActive <= 1'b1;
    end else if (strb.halt) begin
      runActive <= 1'b0;
    end else if (runActive) begin
      if (atZero) begin
        if (cfgPeriodic) countQ <= cfgCount;
        else             runActive <= 1'b0;
      end else begin
        countQ <= countQ - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            irqPending <= 1'b0;
    else if (expireEv)    irqPending <= 1'b1;
    else if (strb.irqClr) irqPending <= 1'b0;
  end
endmodule

// File: rtl/cnt_down_timer.sv
module cnt_down_timer
  import dtmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  localparam int unsigned EN_BIT  = DATA_W - 1;
  localparam int unsigned PER_BIT = DATA_W - 2;

  tmrStrobe_t       strb;
  logic             cfgPeriodic;
  logic [CNT_W-1:0] cfgCount;
  logic             expireEv;
  logic             runActive;

  dtmr_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EN_BIT(EN_BIT), .PER_BIT(PER_BIT),
    .CLR_BIT(PER_BIT), .LOAD_OFF(0), .CTRL_OFF(4)
  ) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .irqPending(irq), .strb(strb), .cfgPeriodic(cfgPeriodic),
    .cfgCount(cfgCount), .rdData(rdData)
  );

  dtmr_core u_core (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgPeriodic(cfgPeriodic),
    .cfgCount(cfgCount), .irqPending(irq), .expireEv(expireEv),
    .runActive(runActive)
  );
endmodule

// File: rtl/dtmr_checker.sv
module dtmr_checker #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic              irq,
  input logic              expireEv,
  input logic              runActive,
  input logic              cfgPeriodic
);
  logic clrWr;
  logic loadWr;
  assign clrWr  = wrEn && (addr == ADDR_W'(4)) && wrData[DATA_W-2];
  assign loadWr = wrEn && (addr == ADDR_W'(0));

  assert_expire_sets_irq_R2: assert property (@(posedge clk) disable iff (!rstN)
    expireEv |=> irq);
  assert_periodic_keeps_R4: assert property (@(posedge clk) disable iff (!rstN)
    expireEv && cfgPeriodic |=> runActive);
  assert_oneshot_stops_R5: assert property (@(posedge clk) disable iff (!rstN)
    expireEv && !cfgPeriodic |=> !runActive);
  assert_irq_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    irq && !clrWr |=> irq);
  assert_clear_drops_R6: assert property (@(posedge clk) disable iff (!rstN)
    clrWr && !expireEv |=> !irq);
  assert_halt_stops_R8: assert property (@(posedge clk) disable iff (!rstN)
    loadWr && !wrData[DATA_W-1] |=> !runActive);
  assert_load_starts_R9: assert property (@(posedge clk) disable iff (!rstN)
    loadWr && wrData[DATA_W-1] |=> runActive);
  assert_expiry_beats_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    clrWr && expireEv |=> irq);
  assert_write_beats_expiry_R11: assert property (@(posedge clk) disable iff (!rstN)
    loadWr |-> !expireEv);
  assert_irq_rise_cause_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(expireEv));
endmodule

bind cnt_down_timer dtmr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .irq(irq), .expireEv(expireEv), .runActive(runActive),
  .cfgPeriodic(cfgPeriodic)
);

// File: tb/cnt_down_timer_bench.sv
module cnt_down_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] CLR = 32'h4000_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;

  int unsigned cyc = 0;
  int checks = 0;
  int failures = 0;

  typedef struct {
    int unsigned at;
    logic        val;
    string       tag;
  } expItem_t;
  expItem_t sbq[$];

  cnt_down_timer u_cnt_down_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compares irq against scoreboard items due this cycle
  always @(negedge clk) begin
    expItem_t item;
    #1;
    while (sbq.size() > 0 && sbq[0].at <= cyc) begin
      item = sbq.pop_front();
      checks++;
      if (item.at != cyc || irq !== item.val) begin
        failures++;
        $display("FAIL %s cycle %0d irq actual=%0b expected=%0b", item.tag, item.at, irq, item.val);
      end
    end
  end

  task automatic expectAt(input int unsigned at, input logic v, input string tag);
    expItem_t it;
    it.at = at; it.val = v; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic checkVal(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a negedge; the write lands on the following edge, returns at next negedge
  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic regRead(input logic [3:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #2;
    checkVal(tag, rdData, exp);
  endtask

  task automatic waitUntil(input int unsigned t);
    while (cyc < t) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int unsigned e;
    int unsigned f;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    checkVal("R1 irq after reset", {31'd0, irq}, 32'd0);
    regRead(4'h0, 32'h0, "R1 load reg after reset");
    regRead(4'h4, 32'h0, "R7 ctrl reg after reset");

    // R2 one-shot N=5, R6 and R7 around the clear
    regWrite(4'h0, 32'h8000_0005); e = cyc;
    expectAt(e+5, 1'b0, "R2 early");
    expectAt(e+6, 1'b1, "R2 expiry");
    regRead(4'h0, 32'h8000_0005, "R1 readback");
    waitUntil(e+8);
    regRead(4'h4, 32'h4000_0000, "R7 pending shown");
    regWrite(4'h4, 32'h0);
    checkVal("R6 write without clear bit", {31'd0, irq}, 32'd1);
    regWrite(4'h4, CLR);
    checkVal("R6 cleared", {31'd0, irq}, 32'd0);
    regRead(4'h4, 32'h0, "R7 pending gone");
    e = cyc;
    expectAt(e+10, 1'b0, "R5 one-shot idle");
    expectAt(e+20, 1'b0, "R5 one-shot idle");
    waitUntil(e+21);

    // R3 zero start value
    regWrite(4'h0, 32'h8000_0000); e = cyc;
    expectAt(e+1, 1'b1, "R3 zero count");
    waitUntil(e+2);
    regWrite(4'h4, CLR);
    checkVal("R6 cleared after R3", {31'd0, irq}, 32'd0);

    // R4 periodic N=3, R10 clear on expiry edge, R8 halt
    regWrite(4'h0, 32'hC000_0003); e = cyc;
    expectAt(e+3, 1'b0, "R4 before first");
    expectAt(e+4, 1'b1, "R4 first expiry");
    waitUntil(e+5);
    regWrite(4'h4, CLR);
    expectAt(e+7, 1'b0, "R4 between");
    expectAt(e+8, 1'b1, "R4 second expiry");
    waitUntil(e+11);
    regWrite(4'h4, CLR);
    expectAt(e+12, 1'b1, "R10 expiry beats clear");
    regWrite(4'h4, CLR);
    checkVal("R4 cleared after third", {31'd0, irq}, 32'd0);
    regWrite(4'h0, 32'h0);
    expectAt(e+16, 1'b0, "R8 halted");
    expectAt(e+25, 1'b0, "R8 halted");
    regRead(4'h0, 32'h0, "R8 readback zero");
    waitUntil(e+26);

    // R8 disable flag clear with non-zero value
    regWrite(4'h0, 32'h0000_0004); e = cyc;
    regRead(4'h0, 32'h0000_0004, "R1 readback disabled");
    expectAt(e+5, 1'b0, "R8 disabled value");
    expectAt(e+10, 1'b0, "R8 disabled value");
    waitUntil(e+11);

    // R9 restart while running
    regWrite(4'h0, 32'h8000_000A); e = cyc;
    waitUntil(e+4);
    regWrite(4'h0, 32'h8000_0002); f = cyc;
    expectAt(f+2, 1'b0, "R9 before new expiry");
    expectAt(f+3, 1'b1, "R9 new expiry");
    waitUntil(f+4);
    regWrite(4'h4, CLR);
    expectAt(f+6, 1'b0, "R9 no old expiry");
    expectAt(f+11, 1'b0, "R9 no old expiry");
    waitUntil(f+12);

    // R11 reload on the expiry edge
    regWrite(4'h0, 32'h8000_0003); e = cyc;
    waitUntil(e+3);
    regWrite(4'h0, 32'h8000_0002); f = cyc;
    checkVal("R11 no expiry on write edge", {31'd0, irq}, 32'd0);
    expectAt(f+2, 1'b0, "R11 restarted");
    expectAt(f+3, 1'b1, "R11 new expiry");
    waitUntil(f+4);
    regWrite(4'h4, CLR);
    regWrite(4'h0, 32'h0);

    // R12 largest count
    regWrite(4'h0, 32'hFFFF_FFFF); e = cyc;
    regRead(4'h0, 32'hDFFF_FFFF, "R12 max readback");
    expectAt(e+100, 1'b0, "R12 long count");
    waitUntil(e+101);
    regWrite(4'h0, 32'h0);

    while (sbq.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule